// File: doc/BRIEF.md
# PWM Time-Base Counter with Two-Stage Prescaler

This block is the shared time base of a PWM channel pair. A 16-bit counter advances once per prescaled tick. The prescaler is built from two 3-bit fields: a power-of-two stage, and a linear stage whose factor is 1 or twice its field value. Downstream compare and action logic reads the count, a strobe for the step onto zero, a strobe for the step onto the period value, and the current count direction.

Software programs the block through a small write port that selects either the control register or the period register. The control register sets:

- the count mode: up, down, up-down or frozen;
- the prescaler fields;
- whether a period write takes effect at once or waits in a shadow copy until the next step onto zero;
- a run mode: halt, finish the current cycle then halt, or run freely.

Top module: `pwm_timebase`

## Requirements
- R1: After reset the count is 0, both strobes are low, the direction flag is 0 (up) and the counter does not advance, because the control register resets to all zeros (run field = halt).
- R2: `wr_sel`=0 writes the control register and `wr_sel`=1 writes the period register. The control fields are: count mode in bits 1:0, direct period load in bit 3, linear prescale field in bits 9:7, power-of-two prescale field in bits 12:10, run mode in bits 15:14.
- R3: The counter advances once every F clocks, where F = 2^pow × (lin == 0 ? 1 : 2·lin). The prescaler restarts from zero whenever either prescale field changes.
- R4: In count mode 0 (up) each step adds 1. A step taken while the count is at or above the active period goes to 0 instead.
- R5: In count mode 1 (down) each step subtracts 1. A step taken at 0 reloads the active period.
- R6: In count mode 2 (up-down) the counter counts up to the period, then down to 0, then repeats. The direction flag shows the direction of the last step (1 = down). Mode 0 leaves it at 0 and mode 1 sets it to 1.
- R7: Count mode 3 holds the count unchanged.
- R8: `zero_o` pulses for one clock when a step lands on 0. `peak_o` pulses for one clock when a step lands on the active period, so up-down mode gives one pulse per peak. Neither strobe is raised without a step.
- R9: With bit 3 = 1 a period write updates the active period on the next clock. With bit 3 = 0 it fills only the shadow copy, which becomes active on the step that lands on 0.
- R10: Run mode 0 blocks every further step. Run modes 2 and 3 count freely. Run mode 1 keeps counting until a step lands on 0, then holds until the run field leaves 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Functional clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 1 | 0 = control register, 1 = period register |
| wr_data | input | 16 | Write data |
| count_o | output | 16 | Current counter value |
| zero_o | output | 1 | One-clock pulse when a step lands on 0 |
| peak_o | output | 1 | One-clock pulse when a step lands on the period |
| down_o | output | 1 | Direction of the last step, 1 = down |

## Verification
The assertions assume that writes come only through the write port, one register per clock, and that a period write that must affect the current step lands well before the tick that uses it. The stimulus therefore changes the run mode or the period only right after an observed step, and uses prescale factors of 6 or more whenever a write must land mid-cycle. The assertions also assume that the count starts within the period when up or down mode begins. The stimulus keeps to this by starting each counting run from a halted count of 0, except for one run that deliberately lowers the period below the current count.

// File: rtl/pwmtb_pkg.sv
package pwmtb_pkg;

    typedef enum logic [1:0] {
        CM_UP   = 2'd0,
        CM_DOWN = 2'd1,
        CM_UPDN = 2'd2,
        CM_HOLD = 2'd3
    } cmode_e;

    typedef enum logic [1:0] {
        RUN_HALT      = 2'd0,
        RUN_CYCLE_END = 2'd1,
        RUN_FREE_ALT  = 2'd2,
        RUN_FREE      = 2'd3
    } runmode_e;

    // Control word, MSB first: run(15:14) rsv(13) pow(12:10) lin(9:7)
    // rsv(6:4) direct(3) rsv(2) mode(1:0)
    typedef struct packed {
        runmode_e   run;
        logic       rsv_hi;
        logic [2:0] pow;
        logic [2:0] lin;
        logic [2:0] rsv_mid;
        logic       direct;
        logic       rsv_lo;
        cmode_e     mode;
    } ctrl_t;

endpackage

// File: rtl/pwmtb_prescaler.sv
module pwmtb_prescaler #(
    parameter int POW_W = 3,
    parameter int LIN_W = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [POW_W-1:0] pow_i,
    input  logic [LIN_W-1:0] lin_i,
    output logic             tick_o
);
    localparam int FW = (1 << POW_W) - 1 + LIN_W + 2;

    typedef struct packed {
        logic [FW-1:0]    cnt;
        logic [POW_W-1:0] pow;
        logic [LIN_W-1:0] lin;
    } pre_st_t;

    pre_st_t       st_d, st_q;
    logic [FW-1:0] lin_fac;
    logic [FW-1:0] factor;
    logic          changed;

    always_comb begin
        lin_fac = (lin_i == '0) ? FW'(1) : FW'({lin_i, 1'b0});
        factor  = lin_fac << pow_i;
        changed = (pow_i != st_q.pow) || (lin_i != st_q.lin);
        tick_o  = !changed && (st_q.cnt == factor - FW'(1));
        st_d     = st_q;
        st_d.pow = pow_i;
        st_d.lin = lin_i;
        if (changed || tick_o) st_d.cnt = '0;
        else                   st_d.cnt = st_q.cnt + FW'(1);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    // R3: with a factor above one, two ticks are never adjacent
    p_tick_gap_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (tick_o && factor != FW'(1)) |=> !tick_o);

endmodule

// File: rtl/pwmtb_regs.sv
module pwmtb_regs
    import pwmtb_pkg::*;
#(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         wr_en,
    input  logic         wr_sel,
    input  logic [W-1:0] wr_data,
    input  logic         zero_evt_i,
    output ctrl_t        ctrl_o,
    output logic [W-1:0] prd_o
);
    typedef struct packed {
        ctrl_t        ctrl;
        logic [W-1:0] shadow;
        logic [W-1:0] active;
    } reg_st_t;

    reg_st_t st_d, st_q;
    logic    wr_ctrl, wr_prd;

    always_comb begin
        wr_ctrl = wr_en && !wr_sel;
        wr_prd  = wr_en &&  wr_sel;
        st_d    = st_q;
        if (wr_ctrl) st_d.ctrl = ctrl_t'(wr_data[15:0]);
        if (wr_prd) st_d.shadow = wr_data;
        if (wr_prd && st_q.ctrl.direct) st_d.active = wr_data;
        else if (zero_evt_i)            st_d.active = st_q.shadow;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign ctrl_o = st_q.ctrl;
    assign prd_o  = st_q.active;

    // R9: the active period only moves on a direct write or a zero step
    p_shadow_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (!zero_evt_i && !(wr_prd && st_q.ctrl.direct)) |=> $stable(prd_o));
    // R9: a direct write shows on the next clock
    p_direct_load_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_prd && st_q.ctrl.direct) |=> (prd_o == $past(wr_data)));

endmodule

// File: rtl/pwmtb_counter.sv
module pwmtb_counter
    import pwmtb_pkg::*;
#(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  ctrl_t        ctrl_i,
    input  logic [W-1:0] prd_i,
    input  logic         tick_i,
    output logic         zero_evt_o,
    output logic [W-1:0] cnt_o,
    output logic         zero_o,
    output logic         peak_o,
    output logic         down_o
);
    typedef struct packed {
        logic [W-1:0] cnt;
        logic         down;
        logic         zero;
        logic         peak;
        logic         held;
    } cnt_st_t;

    cnt_st_t      st_d, st_q;
    logic         step;
    logic [W-1:0] nxt;
    logic         nxt_down;

    always_comb begin
        step = tick_i && (ctrl_i.mode != CM_HOLD) && (ctrl_i.run != RUN_HALT)
               && !(ctrl_i.run == RUN_CYCLE_END && st_q.held);
        nxt      = st_q.cnt;
        nxt_down = st_q.down;
        case (ctrl_i.mode)
            CM_UP: begin
                nxt_down = 1'b0;
                nxt = (st_q.cnt >= prd_i) ? '0 : st_q.cnt + W'(1);
            end
            CM_DOWN: begin
                nxt_down = 1'b1;
                nxt = (st_q.cnt == '0) ? prd_i : st_q.cnt - W'(1);
            end
            CM_UPDN: begin
                if (!st_q.down) begin
                    if (st_q.cnt >= prd_i) begin
                        nxt_down = (prd_i != '0);
                        nxt      = (st_q.cnt == '0) ? '0 : st_q.cnt - W'(1);
                    end else begin
                        nxt = st_q.cnt + W'(1);
                    end
                end else begin
                    if (st_q.cnt == '0) begin
                        nxt_down = 1'b0;
                        nxt      = (prd_i == '0) ? '0 : W'(1);
                    end else begin
                        nxt = st_q.cnt - W'(1);
                    end
                end
            end
            default: ;
        endcase

        zero_evt_o = step && (nxt == '0);
        st_d       = st_q;
        st_d.zero  = zero_evt_o;
        st_d.peak  = step && (nxt == prd_i);
        if (step) begin
            st_d.cnt  = nxt;
            st_d.down = nxt_down;
        end
        if (ctrl_i.run != RUN_CYCLE_END) st_d.held = 1'b0;
        else if (zero_evt_o)             st_d.held = 1'b1;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign cnt_o  = st_q.cnt;
    assign zero_o = st_q.zero;
    assign peak_o = st_q.peak;
    assign down_o = st_q.down;

    // R7: frozen mode keeps the count
    p_freeze_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (ctrl_i.mode == CM_HOLD) |=> $stable(cnt_o));
    // R10: halt run mode keeps the count
    p_halt_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (ctrl_i.run == RUN_HALT) |=> $stable(cnt_o));
    // R8: the zero strobe only comes with a zero count
    p_zero_val_r8: assert property (@(posedge clk) disable iff (!rst_n)
        zero_o |-> (cnt_o == '0));
    // R8: the peak strobe only comes with the period value
    p_peak_val_r8: assert property (@(posedge clk) disable iff (!rst_n)
        peak_o |-> (cnt_o == $past(prd_i)));
    // R4: an up step adds one or wraps to zero
    p_up_step_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (step && ctrl_i.mode == CM_UP) |=>
        (cnt_o == $past(cnt_o) + W'(1) || cnt_o == '0));
    // R6: down mode reports the down direction
    p_down_dir_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (step && ctrl_i.mode == CM_DOWN) |=> down_o);

endmodule

// File: rtl/pwm_timebase.sv
module pwm_timebase
    import pwmtb_pkg::*;
#(
    parameter int W     = 16,
    parameter int POW_W = 3,
    parameter int LIN_W = 3
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         wr_en,
    input  logic         wr_sel,
    input  logic [W-1:0] wr_data,
    output logic [W-1:0] count_o,
    output logic         zero_o,
    output logic         peak_o,
    output logic         down_o
);
    ctrl_t        ctrl;
    logic [W-1:0] prd;
    logic         tick;
    logic         zero_evt;

    pwmtb_regs #(.W(W)) u_regs (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr_en      (wr_en),
        .wr_sel     (wr_sel),
        .wr_data    (wr_data),
        .zero_evt_i (zero_evt),
        .ctrl_o     (ctrl),
        .prd_o      (prd)
    );

    pwmtb_prescaler #(.POW_W(POW_W), .LIN_W(LIN_W)) u_pre (
        .clk    (clk),
        .rst_n  (rst_n),
        .pow_i  (ctrl.pow[POW_W-1:0]),
        .lin_i  (ctrl.lin[LIN_W-1:0]),
        .tick_o (tick)
    );

    pwmtb_counter #(.W(W)) u_cnt (
        .clk        (clk),
        .rst_n      (rst_n),
        .ctrl_i     (ctrl),
        .prd_i      (prd),
        .tick_i     (tick),
        .zero_evt_o (zero_evt),
        .cnt_o      (count_o),
        .zero_o     (zero_o),
        .peak_o     (peak_o),
        .down_o     (down_o)
    );

endmodule

// File: tb/sim_pwm_timebase.sv
`timescale 1ns/1ps
module sim_pwm_timebase;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic        wr_sel = 1'b0;
    logic [15:0] wr_data = '0;
    logic [15:0] count_o;
    logic        zero_o, peak_o, down_o;

    always #5 clk = ~clk;

    pwm_timebase u0 (.*);

    typedef struct {
        logic [15:0] v;
        logic        z;
        logic        p;
        logic        d;
        int          gap;
        string       req;
    } item_t;

    item_t       sb[$];
    int          n_chk = 0, n_fail = 0;
    int          cyc = 0, last_cyc = 0;
    logic [15:0] last_v = '0;
    bit          done = 0;

    task automatic check(string req, logic [31:0] act, logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    function automatic logic [15:0] mk(logic [1:0] run, logic [2:0] pw,
                                       logic [2:0] ln, logic dir, logic [1:0] md);
        return {run, 1'b0, pw, ln, 3'b000, dir, 1'b0, md};
    endfunction

    task automatic wr(logic sel, logic [15:0] data);
        @(posedge clk); #1;
        wr_en = 1'b1; wr_sel = sel; wr_data = data;
        @(posedge clk); #1;
        wr_en = 1'b0;
    endtask

    task automatic push(logic [15:0] v, logic z, logic p, logic d, int gap, string req);
        item_t it;
        it.v = v; it.z = z; it.p = p; it.d = d; it.gap = gap; it.req = req;
        sb.push_back(it);
    endtask

    task automatic settle(logic [15:0] exp_v, string req);
        wait (sb.size() == 0);
        repeat (40) @(posedge clk);
        #2 check(req, count_o, exp_v);
    endtask

    // Monitor: every change of the count pops one expected item
    always @(negedge clk) begin
        if (rst_n && !done) begin
            cyc++;
            if (count_o != last_v) begin
                if (sb.size() == 0) begin
                    n_chk++; n_fail++;
                    $display("FAIL R10: actual count %0h expected no change", count_o);
                end else begin
                    item_t it;
                    it = sb.pop_front();
                    check({it.req, " value"}, count_o, it.v);
                    check("R8 zero strobe", zero_o, it.z);
                    check("R8 peak strobe", peak_o, it.p);
                    check("R6 direction", down_o, it.d);
                    if (it.gap != 0) check("R3 step spacing", cyc - last_cyc, it.gap);
                end
                last_v   = count_o;
                last_cyc = cyc;
            end else if (zero_o || peak_o) begin
                n_chk++; n_fail++;
                $display("FAIL R8: actual strobe %0b%0b expected 00 without step", zero_o, peak_o);
            end
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        repeat (20) @(posedge clk);
        #2;
        // R1 reset state
        check("R1 count", count_o, 0);
        check("R1 zero", zero_o, 0);
        check("R1 peak", peak_o, 0);
        check("R1 dir", down_o, 0);

        // R4 up, factor 1, direct period 4, stop at cycle end (R2 fields)
        wr(0, mk(0, 0, 0, 1, 0));
        wr(1, 16'd4);
        push(1, 0, 0, 0, 0, "R4"); push(2, 0, 0, 0, 1, "R4");
        push(3, 0, 0, 0, 1, "R4"); push(4, 0, 1, 0, 1, "R4");
        push(0, 1, 0, 0, 1, "R4");
        wr(0, mk(1, 0, 0, 1, 0));
        settle(0, "R10 cycle end hold");

        // R3 factor 6 (lin 3), free run mode 2, then cycle end mid-way (R10)
        wr(0, mk(0, 0, 3, 1, 0));
        for (int k = 0; k < 2; k++) begin
            push(1, 0, 0, 0, (k == 0) ? 0 : 6, "R3");
            push(2, 0, 0, 0, 6, "R3"); push(3, 0, 0, 0, 6, "R3");
            push(4, 0, 1, 0, 6, "R3"); push(0, 1, 0, 0, 6, "R3");
        end
        wr(0, mk(2, 0, 3, 1, 0));
        wait (sb.size() == 3);
        wr(0, mk(1, 0, 3, 1, 0));
        settle(0, "R10 free then cycle end");

        // R5 down, factor 8 (pow 3)
        wr(0, mk(0, 3, 0, 1, 1));
        push(4, 0, 1, 1, 0, "R5"); push(3, 0, 0, 1, 8, "R5");
        push(2, 0, 0, 1, 8, "R5"); push(1, 0, 0, 1, 8, "R5");
        push(0, 1, 0, 1, 8, "R5");
        wr(0, mk(1, 3, 0, 1, 1));
        settle(0, "R5 down end");

        // R6 up-down, factor 12 (pow 1, lin 3), period 3
        wr(0, mk(0, 1, 3, 1, 2));
        wr(1, 16'd3);
        push(1, 0, 0, 0, 0, "R6"); push(2, 0, 0, 0, 12, "R6");
        push(3, 0, 1, 0, 12, "R6"); push(2, 0, 0, 1, 12, "R6");
        push(1, 0, 0, 1, 12, "R6"); push(0, 1, 0, 1, 12, "R6");
        wr(0, mk(1, 1, 3, 1, 2));
        settle(0, "R6 updown end");

        // R9 shadow load: active 3 this cycle, shadow 6 from the next
        wr(0, mk(0, 1, 0, 0, 0));
        push(1, 0, 0, 0, 0, "R9"); push(2, 0, 0, 0, 2, "R9");
        push(3, 0, 1, 0, 2, "R9"); push(0, 1, 0, 0, 2, "R9");
        wr(0, mk(1, 1, 0, 0, 0));
        wait (sb.size() == 3);
        wr(1, 16'd6);
        settle(0, "R9 shadow first cycle");
        wr(0, mk(0, 1, 0, 0, 0));
        push(1, 0, 0, 0, 0, "R9");
        for (int v = 2; v <= 5; v++) push(v[15:0], 0, 0, 0, 2, "R9");
        push(6, 0, 1, 0, 2, "R9"); push(0, 1, 0, 0, 2, "R9");
        wr(0, mk(1, 1, 0, 0, 0));
        settle(0, "R9 shadow second cycle");

        // R10 halt mid-cycle, factor 8
        wr(0, mk(0, 3, 0, 1, 0));
        wr(1, 16'd6);
        for (int v = 1; v <= 5; v++) push(v[15:0], 0, 0, 0, (v == 1) ? 0 : 8, "R10");
        push(6, 0, 1, 0, 8, "R10"); push(0, 1, 0, 0, 8, "R10");
        wr(0, mk(3, 3, 0, 1, 0));
        wait (sb.size() == 3);
        wr(0, mk(0, 3, 0, 1, 0));
        repeat (80) @(posedge clk);
        #2;
        check("R10 halt queue", sb.size(), 3);
        check("R10 halt count", count_o, 4);
        sb.delete();

        // R7 freeze with free run selected
        wr(0, mk(3, 3, 0, 1, 3));
        repeat (80) @(posedge clk);
        #2 check("R7 frozen count", count_o, 4);

        // R4 period lowered below the count wraps to zero
        wr(0, mk(0, 3, 0, 1, 0));
        wr(1, 16'd10);
        push(5, 0, 0, 0, 0, "R4"); push(6, 0, 0, 0, 8, "R4");
        push(7, 0, 0, 0, 8, "R4"); push(0, 1, 0, 0, 8, "R4");
        wr(0, mk(1, 3, 0, 1, 0));
        wait (sb.size() == 1);
        wr(1, 16'd5);
        settle(0, "R4 lowered period");

        done = 1;
        $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
        $finish;
    end

endmodule